// File: doc/BRIEF.md
# Multi-Channel Gamma Correction Table

This block applies gamma correction to RGB pixels for several output channels. Each channel has three tables, one each for red, green and blue, and every table has one entry for each possible component value. A pixel arrives with a channel number. Each of its three components indexes that channel's table for the same colour, and the three results leave together one clock later. Each channel has its own enable bit. When the bit is clear, the pixel goes through unchanged, which gives the same result as an identity table.

Software loads and inspects the tables through two registers. The first is an address register, which also carries an auto-increment flag. The second is a data port that reaches the entry at the current address. All entries share one flat address space. The space is ordered by channel first. Inside each channel come the red block, then the green block, then the blue block. This ordering lets software load a whole channel, or every channel, as one continuous stream of data-port writes.

Top module: `gamma_lut`

## Requirements
- R1: After reset the address register reads zero with auto-increment clear, `pix_valid_o` is 0 and `pix_o` is 0.
- R2: A write with `reg_sel_i`=0 loads the address from `reg_wdata_i[AW-1:0]` and the auto-increment flag from `reg_wdata_i[BUS_W-1]`. Here AW is the number of bits needed for NUM_CH*3*2^DATA_W addresses. A loaded value of NUM_CH*3*2^DATA_W or more sets the address to 0. A read with `reg_sel_i`=0 returns the flag at bit BUS_W-1 and the address in the low AW bits, with zeros in every other bit.
- R3: A write with `reg_sel_i`=1 stores `reg_wdata_i[DATA_W-1:0]` at the current address. With `reg_sel_i`=1, `reg_rdata_o` shows the entry at the current address, zero-extended, in the same cycle.
- R4: While auto-increment is set, each clock with a data-port strobe (`reg_we_i` or `reg_re_i` with `reg_sel_i`=1) advances the address by exactly one, even when both strobes are high.
- R5: While auto-increment is clear, data-port reads and writes leave the address unchanged.
- R6: An auto-increment step from the last address (NUM_CH*3*2^DATA_W-1) goes to address 0.
- R7: Address a selects channel a/(3*2^DATA_W). Within that channel, block (a mod 3*2^DATA_W)/2^DATA_W selects the colour: 0 red, 1 green, 2 blue. The entry index inside the block is a mod 2^DATA_W.
- R8: When the pixel's channel is enabled, each output component equals that channel's entry for the same colour, indexed by the input component. Pixels are packed with red in the top DATA_W bits and blue in the bottom DATA_W bits.
- R9: When `gamma_en_i[pix_ch_i]` is 0, or `pix_ch_i` is NUM_CH or above, `pix_o` equals `pix_i` as captured.
- R10: `pix_valid_o` is `pix_valid_i` delayed by one clock. `pix_o` takes its new value on the same edge, and `pix_o` holds its value while `pix_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_sel_i | input | 1 | 0 selects the address register, 1 selects the data port |
| reg_wdata_i | input | BUS_W | Write data |
| reg_rdata_o | output | BUS_W | Read data of the selected register |
| gamma_en_i | input | NUM_CH | Per-channel table enable |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ch_i | input | CH_W | Channel number of the input pixel |
| pix_i | input | 3*DATA_W | Input pixel {r,g,b} |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 3*DATA_W | Corrected pixel {r,g,b} |

## Verification
The bench builds the block with NUM_CH=3, DATA_W=4 and BUS_W=32. This gives 16-entry tables and a 144-entry address space. One auto-incrementing stream can fill every table and wrap the address back to zero in a few hundred cycles, and every channel/colour boundary of the layout is checked against a bench-side model. With three channels, CH_W is 2, so channel code 3 can be driven. This exercises the bypass for channels that do not exist, alongside the per-channel enable bits.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int unsigned NUM_COLOURS = 3;

  // bit offset of colour c inside a packed {r,g,b} pixel
  function automatic int unsigned comp_lsb(input int unsigned c, input int unsigned w);
    return (NUM_COLOURS - 1 - c) * w;
  endfunction
endpackage

// File: rtl/gamma_table.sv
module gamma_table #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_CH = 3,
  localparam int unsigned DEPTH = 1 << DATA_W,
  localparam int unsigned SIZE  = NUM_CH * DEPTH,
  localparam int unsigned IW    = $clog2(SIZE)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IW-1:0]     bus_raddr_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [IW-1:0]     pix_raddr_i,
  output logic [DATA_W-1:0] pix_rdata_o
);
  logic [DATA_W-1:0] mem [SIZE];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign bus_rdata_o = mem[bus_raddr_i];
  assign pix_rdata_o = mem[pix_raddr_i];
endmodule

// File: rtl/gamma_addr_ctrl.sv
module gamma_addr_ctrl #(
  parameter int unsigned TOTAL = 2304,
  parameter int unsigned BUS_W = 32,
  localparam int unsigned AW   = $clog2(TOTAL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_we_i,
  input  logic [BUS_W-1:0] addr_wdata_i,
  input  logic             data_acc_i,
  output logic [AW-1:0]    addr_o,
  output logic             autoinc_o
);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

  logic [AW-1:0] load_val;
  logic          load_ok;

  assign load_val = addr_wdata_i[AW-1:0];
  assign load_ok  = {1'b0, load_val} < (AW+1)'(TOTAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o    <= '0;
      autoinc_o <= 1'b0;
    end else if (addr_we_i) begin
      addr_o    <= load_ok ? load_val : '0;
      autoinc_o <= addr_wdata_i[BUS_W-1];
    end else if (data_acc_i && autoinc_o) begin
      addr_o <= (addr_o == LAST) ? '0 : addr_o + AW'(1);
    end
  end
endmodule

// File: rtl/gamma_pixel_path.sv
module gamma_pixel_path #(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             use_lut_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] lut_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] pix_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) pix_o <= use_lut_i ? lut_i : pix_i;
    end
  end
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUS_W  = 32,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned PIX_W = NUM_COLOURS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic              reg_sel_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  input  logic [NUM_CH-1:0] gamma_en_i,
  input  logic              pix_valid_i,
  input  logic [CH_W-1:0]   pix_ch_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_o
);
  localparam int unsigned DEPTH    = 1 << DATA_W;
  localparam int unsigned CH_SPAN  = NUM_COLOURS * DEPTH;
  localparam int unsigned TOTAL    = NUM_CH * CH_SPAN;
  localparam int unsigned AW       = $clog2(TOTAL);
  localparam int unsigned IW       = $clog2(NUM_CH * DEPTH);
  localparam int unsigned CH_SLOTS = 1 << CH_W;

  logic [AW-1:0] cur_addr;
  logic          cur_ai;
  logic          data_we, addr_we, data_acc;

  assign data_we  = reg_we_i & reg_sel_i;
  assign addr_we  = reg_we_i & ~reg_sel_i;
  assign data_acc = (reg_we_i | reg_re_i) & reg_sel_i;

  gamma_addr_ctrl #(.TOTAL(TOTAL), .BUS_W(BUS_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_we_i   (addr_we),
    .addr_wdata_i(reg_wdata_i),
    .data_acc_i  (data_acc),
    .addr_o      (cur_addr),
    .autoinc_o   (cur_ai)
  );

  // flat address -> channel / colour block / entry
  logic [AW-1:0] bus_ch, bus_rem, bus_col;
  logic [IW-1:0] bus_lin;

  assign bus_ch  = cur_addr / AW'(CH_SPAN);
  assign bus_rem = cur_addr % AW'(CH_SPAN);
  assign bus_col = bus_rem / AW'(DEPTH);
  assign bus_lin = IW'(bus_ch * AW'(DEPTH) + (bus_rem % AW'(DEPTH)));

  // pixel side channel select; absent channels bypass
  logic [CH_SLOTS-1:0] en_pad;
  logic                ch_ok, use_lut;
  logic [CH_W-1:0]     ch_sel;

  assign en_pad  = CH_SLOTS'(gamma_en_i);
  assign ch_ok   = {1'b0, pix_ch_i} < (CH_W+1)'(NUM_CH);
  assign ch_sel  = ch_ok ? pix_ch_i : '0;
  assign use_lut = en_pad[pix_ch_i];

  logic [DATA_W-1:0] bus_dat [NUM_COLOURS];
  logic [PIX_W-1:0]  lut_pix;

  for (genvar c = 0; c < NUM_COLOURS; c++) begin : g_col
    localparam int unsigned LSB = comp_lsb(c, DATA_W);
    logic          hit;
    logic [IW-1:0] pix_lin;

    assign hit     = (bus_col == AW'(c));
    assign pix_lin = IW'({ch_sel, pix_i[LSB +: DATA_W]});

    gamma_table #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_tab (
      .clk_i      (clk_i),
      .we_i       (data_we & hit),
      .waddr_i    (bus_lin),
      .wdata_i    (reg_wdata_i[DATA_W-1:0]),
      .bus_raddr_i(bus_lin),
      .bus_rdata_o(bus_dat[c]),
      .pix_raddr_i(pix_lin),
      .pix_rdata_o(lut_pix[LSB +: DATA_W])
    );
  end

  logic [DATA_W-1:0] bus_entry;

  always_comb begin
    bus_entry = '0;
    for (int c = 0; c < NUM_COLOURS; c++)
      if (bus_col == AW'(c)) bus_entry = bus_dat[c];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) begin
      reg_rdata_o[DATA_W-1:0] = bus_entry;
    end else begin
      reg_rdata_o[BUS_W-1] = cur_ai;
      reg_rdata_o[AW-1:0]  = cur_addr;
    end
  end

  gamma_pixel_path #(.PIX_W(PIX_W)) u_pix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (pix_valid_i),
    .use_lut_i(use_lut),
    .pix_i    (pix_i),
    .lut_i    (lut_pix),
    .valid_o  (pix_valid_o),
    .pix_o    (pix_o)
  );
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned PIX_W = 3 * DATA_W,
  localparam int unsigned TOTAL = NUM_CH * 3 * (1 << DATA_W),
  localparam int unsigned AW    = $clog2(TOTAL)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic              reg_sel_i,
  input logic [NUM_CH-1:0] gamma_en_i,
  input logic              pix_valid_i,
  input logic [CH_W-1:0]   pix_ch_i,
  input logic [PIX_W-1:0]  pix_i,
  input logic              pix_valid_o,
  input logic [PIX_W-1:0]  pix_o,
  input logic [AW-1:0]     cur_addr,
  input logic              cur_ai
);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);
  localparam int unsigned SLOTS  = 1 << CH_W;

  logic [SLOTS-1:0] en_ext;
  logic             acc;

  assign en_ext = SLOTS'(gamma_en_i);
  assign acc    = reg_sel_i && (reg_we_i || reg_re_i);

  a_r4_autoinc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cur_ai && cur_addr != LAST) |=> cur_addr == $past(cur_addr) + AW'(1));

  a_r5_addr_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !cur_ai) |=> $stable(cur_addr));

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cur_ai && cur_addr == LAST) |=> cur_addr == '0);

  a_r2_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cur_addr} < (AW+1)'(TOTAL));

  a_r10_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> pix_valid_o);

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> (!pix_valid_o && $stable(pix_o)));

  a_r9_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !en_ext[pix_ch_i]) |=> pix_o == $past(pix_i));
endmodule

bind gamma_lut gamma_lut_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_re_i   (reg_re_i),
  .reg_sel_i  (reg_sel_i),
  .gamma_en_i (gamma_en_i),
  .pix_valid_i(pix_valid_i),
  .pix_ch_i   (pix_ch_i),
  .pix_i      (pix_i),
  .pix_valid_o(pix_valid_o),
  .pix_o      (pix_o),
  .cur_addr   (cur_addr),
  .cur_ai     (cur_ai)
);

// File: tb/gamma_lut_test.sv
module gamma_lut_test;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned CH_W   = 2;
  localparam int unsigned PIX_W  = 12;
  localparam int unsigned TOTAL  = 144;

  typedef struct packed {
    logic [1:0]  ch;
    logic [2:0]  en;
    logic [11:0] pin;
    logic [11:0] pexp;
  } vec_t;

  // table content: entry = idx ^ (3*ch + colour + 1)
  localparam vec_t VECS [8] = '{
    '{2'd0, 3'b111, 12'h000, 12'h123},
    '{2'd1, 3'b111, 12'h59F, 12'h1C9},
    '{2'd2, 3'b111, 12'hF08, 12'h881},
    '{2'd2, 3'b011, 12'h345, 12'h345},
    '{2'd3, 3'b111, 12'hABC, 12'hABC},
    '{2'd0, 3'b110, 12'h777, 12'h777},
    '{2'd1, 3'b010, 12'h234, 12'h662},
    '{2'd0, 3'b001, 12'hFFF, 12'hEDC}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we = 1'b0, reg_re = 1'b0, reg_sel = 1'b0;
  logic [BUS_W-1:0]  reg_wdata = '0;
  logic [BUS_W-1:0]  reg_rdata;
  logic [NUM_CH-1:0] gamma_en = '0;
  logic              pix_valid = 1'b0;
  logic [CH_W-1:0]   pix_ch = '0;
  logic [PIX_W-1:0]  pix_in = '0;
  logic              pix_valid_o;
  logic [PIX_W-1:0]  pix_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gamma_lut #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .BUS_W(BUS_W)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we),
    .reg_re_i   (reg_re),
    .reg_sel_i  (reg_sel),
    .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .gamma_en_i (gamma_en),
    .pix_valid_i(pix_valid),
    .pix_ch_i   (pix_ch),
    .pix_i      (pix_in),
    .pix_valid_o(pix_valid_o),
    .pix_o      (pix_out)
  );

  function automatic logic [3:0] model(input int a);
    int ch, col, idx;
    ch  = a / 48;
    col = (a % 48) / 16;
    idx = a % 16;
    return 4'((idx ^ (3 * ch + col + 1)) & 15);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic re, input logic sel, input logic [BUS_W-1:0] d);
    @(negedge clk);
    reg_we = we; reg_re = re; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_re = 1'b0;
  endtask

  task automatic peek(input logic sel);
    reg_sel = sel;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 valid after reset", 32'(pix_valid_o), 0);
    chk("R1 pix after reset", 32'(pix_out), 0);
    chk("R1 addr after reset", reg_rdata, 0);

    bus_op(1, 0, 0, 32'h8000_0000);
    peek(0);
    chk("R2 addr readback ai", reg_rdata, 32'h8000_0000);

    for (int a = 0; a < TOTAL; a++) bus_op(1, 0, 1, 32'(model(a)));
    peek(0);
    chk("R6 wrap after full fill", reg_rdata, 32'h8000_0000);

    gamma_en = 3'b111;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pix_valid = 1'b1; pix_ch = VECS[i].ch; gamma_en = VECS[i].en; pix_in = VECS[i].pin;
      @(negedge clk);
      chk($sformatf("R8 R9 R7 vector %0d pixel", i), 32'(pix_out), 32'(VECS[i].pexp));
      chk($sformatf("R10 vector %0d valid", i), 32'(pix_valid_o), 1);
    end
    pix_valid = 1'b0; pix_in = 12'h555; gamma_en = 3'b000;
    @(negedge clk);
    chk("R10 valid drops", 32'(pix_valid_o), 0);
    chk("R10 pix holds", 32'(pix_out), 32'h0EDC);

    bus_op(1, 0, 0, 32'd47);
    peek(1);
    chk("R7 entry 47 blue ch0", reg_rdata, 32'(model(47)));
    bus_op(0, 1, 1, 0);
    peek(0);
    chk("R5 read keeps addr", reg_rdata, 32'd47);

    bus_op(1, 0, 0, 32'd48);
    peek(1);
    chk("R7 entry 48 red ch1", reg_rdata, 32'(model(48)));
    bus_op(1, 0, 1, 32'hFFFF_FFF9);
    peek(1);
    chk("R3 write low bits stored", reg_rdata, 32'h9);
    peek(0);
    chk("R5 write keeps addr", reg_rdata, 32'd48);

    bus_op(1, 0, 0, 32'h8000_0064);
    bus_op(0, 1, 1, 0);
    peek(0);
    chk("R4 read step", reg_rdata, 32'h8000_0065);
    bus_op(1, 1, 1, 32'h5);
    peek(0);
    chk("R4 single step on write+read", reg_rdata, 32'h8000_0066);
    bus_op(1, 0, 0, 32'd101);
    peek(1);
    chk("R3 R4 write landed at 101", reg_rdata, 32'h5);

    bus_op(1, 0, 0, 32'h8000_008F);
    bus_op(0, 1, 1, 0);
    peek(0);
    chk("R6 wrap from last", reg_rdata, 32'h8000_0000);

    bus_op(1, 0, 0, 32'd200);
    peek(0);
    chk("R2 out of range load", reg_rdata, 32'h0);

    @(negedge clk);
    pix_valid = 1'b1; pix_ch = 2'd1; gamma_en = 3'b111; pix_in = 12'h000;
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R8 lookup sees rewritten entry", 32'(pix_out), 32'h0956);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule